// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It reads a two-level page table from memory through a simple request/acknowledge port. A request carries the virtual address and an access type (load, store or instruction fetch). The walker reads one directory entry, then one table entry. It finishes with a one-cycle completion pulse that carries either the physical address or a fault with a two-bit cause.

The directory base sits in a writable register that software reloads when it switches address space. A write that arrives while a walk is in flight does not disturb that walk. The register keeps the value and applies it when the walk completes, so the next request is walked under the new address space.

Entries use one word format. Bit 0 is the valid flag. Bits 1, 2 and 3 grant read, write and execute. Bits 31:12 hold a frame number. Directory entries use only the valid flag and the frame. Pages are 4 KB.

Top module: `pgw_top`

## Requirements
- R1: A request accepted while `xl_ready` is high first reads the directory entry at address {base frame, vaddr[31:22], 2'b00}. The base frame is the value of the base register in the accepting cycle.
- R2: After a valid directory entry, the walker reads the table entry at address {directory frame (entry bits 31:12), vaddr[21:12], 2'b00}.
- R3: If the table entry is valid and permits the access, the result is `xl_fault`=0, `xl_cause`=0 and `xl_paddr` = {table frame, vaddr[11:0]}.
- R4: A directory entry with bit 0 clear ends the walk with `xl_fault`=1, `xl_cause`=1 and `xl_paddr`=0, and no table read is issued.
- R5: A table entry with bit 0 clear ends the walk with `xl_fault`=1, `xl_cause`=2 and `xl_paddr`=0, whatever its permission bits hold.
- R6: The access codes are 0 load, 1 store, 2 fetch and 3 reserved. A load needs entry bit 1, a store needs bit 2 and a fetch needs bit 3. The reserved code never has permission. A refused access gives `xl_fault`=1, `xl_cause`=3 and `xl_paddr`=0.
- R7: `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is sampled high. Any latency of one or more cycles is accepted.
- R8: Each accepted request produces exactly one `xl_done` pulse of one cycle. `xl_ready` is low from acceptance until after that pulse, and `mem_req` is never high while `xl_ready` is high.
- R9: A base write while the walker is idle applies from the next cycle.
- R10: A base write during a walk leaves that walk unchanged. The last such write takes effect for the following request.
- R11: While reset is applied, `xl_ready`=1, `xl_done`=0, `xl_fault`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req | input | 1 | Translation request strobe |
| xl_vaddr | input | 32 | Virtual address |
| xl_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| xl_ready | output | 1 | Walker idle, request accepted this cycle |
| xl_done | output | 1 | One-cycle completion pulse |
| xl_fault | output | 1 | Walk ended in a fault |
| xl_cause | output | 2 | 0 none, 1 bad directory entry, 2 bad table entry, 3 permission |
| xl_paddr | output | 32 | Translated physical address |
| base_we | input | 1 | Base register write enable |
| base_wdata | input | 32 | New directory base (bits 31:12 used) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Entry address to read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
Each access type is exercised against entries that grant exactly one permission. A swapped bit-to-access mapping therefore shows up as a wrong cause. Invalid entries that carry permission bits expose a walker that checks permissions before validity. Every memory read address is compared in order, so a walker that reads the table after an invalid directory entry, or that builds an index from the wrong bits, fails at once. Two base writes land in the middle of a slow walk, followed by another request. A register that drops deferred writes, keeps the first one, or lets a write leak into the running walk then gives a wrong result.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ENT_VALID = 0;
  localparam int ENT_R     = 1;
  localparam int ENT_W     = 2;
  localparam int ENT_X     = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CS_NONE    = 2'd0,
    CS_DIR_INV = 2'd1,
    CS_TBL_INV = 2'd2,
    CS_PERM    = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR,
    ST_TBL,
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/pgw_base.sv
module pgw_base #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PA_W-1:0]       wr_data,
  input  logic                  busy,
  input  logic                  rel_i,
  output logic [PA_W-OFF_W-1:0] base_o
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] pend_q;
  logic               pend_v;
  logic [FRAME_W-1:0] wr_frame;

  assign wr_frame = wr_data[PA_W-1 -: FRAME_W];
  assign base_o   = base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (!busy) begin
      if (wr_en) base_q <= wr_frame;
      pend_v <= 1'b0;
    end else if (rel_i) begin
      if (wr_en)       base_q <= wr_frame;
      else if (pend_v) base_q <= pend_q;
      pend_v <= 1'b0;
    end else if (wr_en) begin
      pend_q <= wr_frame;
      pend_v <= 1'b1;
    end
  end

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !rel_i) |=> $stable(base_q)); // R10
  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (rst)
    (rel_i && pend_v && !wr_en) |=> (base_q == $past(pend_q))); // R10
  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en) |=> (base_q == $past(wr_frame))); // R9
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm (
  input  logic [3:0] flags,
  input  logic [1:0] acc,
  output logic       allow
);
  import pgw_pkg::*;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_LOAD:  allow = flags[ENT_R];
      ACC_STORE: allow = flags[ENT_W];
      ACC_FETCH: allow = flags[ENT_X];
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/pgw_walk.sv
module pgw_walk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic [VA_W-1:0]       vaddr,
  input  logic [1:0]            acc,
  input  logic [PA_W-OFF_W-1:0] base_frame,
  output logic                  ready,
  output logic                  fin,
  output logic                  mem_req,
  output logic [PA_W-1:0]       mem_addr,
  input  logic                  mem_ack,
  input  logic [ENT_W-1:0]      mem_rdata,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            cause,
  output logic [PA_W-1:0]       paddr
);
  import pgw_pkg::*;

  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LO_W    = VA_W - IDX_W;
  localparam int BYTE_W  = OFF_W - IDX_W;

  walk_st_e          st_q;
  logic [LO_W-1:0]   va_lo_q;
  logic [1:0]        acc_q;
  logic              mem_req_q;
  logic [PA_W-1:0]   mem_addr_q;
  logic              done_q;
  logic              fault_q;
  logic [1:0]        cause_q;
  logic [PA_W-1:0]   paddr_q;

  logic [IDX_W-1:0]   dir_idx;
  logic [IDX_W-1:0]   tbl_idx;
  logic [OFF_W-1:0]   pg_off;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_valid;
  logic               allow;

  assign dir_idx   = vaddr[VA_W-1 -: IDX_W];
  assign tbl_idx   = va_lo_q[LO_W-1 -: IDX_W];
  assign pg_off    = va_lo_q[OFF_W-1:0];
  assign ent_frame = mem_rdata[ENT_W-1 -: FRAME_W];
  assign ent_valid = mem_rdata[ENT_VALID];

  pgw_perm u_perm (
    .flags (mem_rdata[3:0]),
    .acc   (acc_q),
    .allow (allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      va_lo_q    <= '0;
      acc_q      <= '0;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      cause_q    <= CS_NONE;
      paddr_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req) begin
            va_lo_q    <= vaddr[LO_W-1:0];
            acc_q      <= acc;
            mem_addr_q <= {base_frame, dir_idx, {BYTE_W{1'b0}}};
            mem_req_q  <= 1'b1;
            st_q       <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            if (!ent_valid) begin
              mem_req_q <= 1'b0;
              done_q    <= 1'b1;
              fault_q   <= 1'b1;
              cause_q   <= CS_DIR_INV;
              paddr_q   <= '0;
              st_q      <= ST_FIN;
            end else begin
              mem_addr_q <= {ent_frame, tbl_idx, {BYTE_W{1'b0}}};
              st_q       <= ST_TBL;
            end
          end
        end
        ST_TBL: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            done_q    <= 1'b1;
            st_q      <= ST_FIN;
            if (!ent_valid) begin
              fault_q <= 1'b1;
              cause_q <= CS_TBL_INV;
              paddr_q <= '0;
            end else if (!allow) begin
              fault_q <= 1'b1;
              cause_q <= CS_PERM;
              paddr_q <= '0;
            end else begin
              fault_q <= 1'b0;
              cause_q <= CS_NONE;
              paddr_q <= {ent_frame, pg_off};
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready    = (st_q == ST_IDLE);
  assign fin      = (st_q == ST_FIN);
  assign mem_req  = mem_req_q;
  assign mem_addr = mem_addr_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign cause    = cause_q;
  assign paddr    = paddr_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> !mem_req); // R8
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (cause == 2'd0)); // R3
  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (cause != 2'd0 && paddr == '0)); // R4
endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xl_req,
  input  logic [VA_W-1:0]  xl_vaddr,
  input  logic [1:0]       xl_acc,
  output logic             xl_ready,
  output logic             xl_done,
  output logic             xl_fault,
  output logic [1:0]       xl_cause,
  output logic [PA_W-1:0]  xl_paddr,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] base_frame;
  logic               walk_fin;

  pgw_base #(.PA_W(PA_W), .OFF_W(OFF_W)) u_base (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (base_we),
    .wr_data (base_wdata),
    .busy    (!xl_ready),
    .rel_i   (walk_fin),
    .base_o  (base_frame)
  );

  pgw_walk #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .req        (xl_req),
    .vaddr      (xl_vaddr),
    .acc        (xl_acc),
    .base_frame (base_frame),
    .ready      (xl_ready),
    .fin        (walk_fin),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .done       (xl_done),
    .fault      (xl_fault),
    .cause      (xl_cause),
    .paddr      (xl_paddr)
  );
endmodule

// File: tb/pgw_top_bench.sv
module pgw_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xl_req = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic [1:0]  xl_acc = '0;
  logic        xl_ready, xl_done, xl_fault;
  logic [1:0]  xl_cause;
  logic [31:0] xl_paddr;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pgw_top u_pgw_top (
    .clk(clk), .rst(rst), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_acc(xl_acc),
    .xl_ready(xl_ready), .xl_done(xl_done), .xl_fault(xl_fault), .xl_cause(xl_cause),
    .xl_paddr(xl_paddr), .base_we(base_we), .base_wdata(base_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] addr_q[$];
  logic [31:0] pmem[logic [31:0]];
  logic [31:0] tb_base = '0;
  int          lat_sel = 0;
  int          fixed_lat = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: computes the expected result and pushes it to the scoreboard
  task automatic issue(input logic [31:0] va, input logic [1:0] acc, input string tag);
    logic [31:0] da, de, ta, te;
    logic        ok;
    logic [34:0] e;
    da = {tb_base[31:12], va[31:22], 2'b00};
    de = rd(da);
    addr_q.push_back(da);
    if (!de[0]) e = {1'b1, 2'd1, 32'h0};                     // R4
    else begin
      ta = {de[31:12], va[21:12], 2'b00};                    // R2
      addr_q.push_back(ta);
      te = rd(ta);
      case (acc)
        2'd0: ok = te[1];
        2'd1: ok = te[2];
        2'd2: ok = te[3];
        default: ok = 1'b0;
      endcase
      if (!te[0])  e = {1'b1, 2'd2, 32'h0};                   // R5
      else if (!ok) e = {1'b1, 2'd3, 32'h0};                  // R6
      else e = {1'b0, 2'd0, te[31:12], va[11:0]};             // R3
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!xl_ready) @(negedge clk);
    xl_req = 1'b1; xl_vaddr = va; xl_acc = acc;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  task automatic wr_base(input logic [31:0] v);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    tb_base = v;
  endtask

  task automatic wait_idle;
    while (exp_q.size() != 0 || !xl_ready) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (!rst && xl_done) begin
      if (exp_q.size() == 0) chk("R8 unexpected done", 64'd1, 64'd0);
      else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {29'd0, xl_fault, xl_cause, xl_paddr}, {29'd0, e});
      end
    end
  end

  // memory responder with varying latency; checks each read address
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        int lat;
        if (addr_q.size() == 0) chk("R1 R2 extra memory read", {32'd0, mem_addr}, 64'd0);
        else chk("R1 R2 entry address", {32'd0, mem_addr}, {32'd0, addr_q.pop_front()});
        lat = (fixed_lat > 0) ? fixed_lat : 1 + (lat_sel % 4);
        lat_sel++;
        for (int i = 1; i < lat; i++) @(negedge clk);
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // address space A: directory frame 0x00010
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0001_0008] = 32'h0003_000E;   // invalid directory entry with flags
    pmem[32'h0001_0FFC] = 32'h0004_0001;
    pmem[32'h0002_0000] = 32'h1234_500F;   // RWX
    pmem[32'h0002_0004] = 32'h2345_6003;   // R only
    pmem[32'h0002_0008] = 32'h3456_7005;   // W only
    pmem[32'h0002_000C] = 32'h4567_8009;   // X only
    pmem[32'h0002_0010] = 32'h7777_700E;   // invalid with flags
    pmem[32'h0004_0FFC] = 32'h00AB_C007;   // RW
    // address space B: directory frame 0x00050
    pmem[32'h0005_0004] = 32'h0006_0001;
    pmem[32'h0006_0000] = 32'hABCD_E00F;

    repeat (2) @(negedge clk);
    chk("R11 ready in reset", {63'd0, xl_ready}, 64'd1);
    chk("R11 done in reset", {63'd0, xl_done}, 64'd0);
    chk("R11 fault in reset", {63'd0, xl_fault}, 64'd0);
    chk("R11 mem_req in reset", {63'd0, mem_req}, 64'd0);
    rst = 1'b0;

    wr_base(32'h0001_0000);                                   // R9
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 4; a++)
        issue(32'h0040_0000 | (k << 12) | (12'h1A4 + k * 4), 2'(a), "R3 R5 R6 access pattern");
    issue(32'h0080_0ABC, 2'd0, "R4 invalid directory entry");
    issue(32'h0140_0000, 2'd2, "R4 empty directory slot");
    issue(32'hFFFF_FFFF, 2'd0, "R1 R3 top address load");
    issue(32'hFFFF_FFFF, 2'd1, "R3 top address store");
    issue(32'hFFFF_FFFF, 2'd2, "R6 top address fetch refused");
    wait_idle();

    wr_base(32'h0005_0000);                                   // R9 idle write
    issue(32'h0040_0123, 2'd0, "R9 new space after idle write");
    wait_idle();

    fixed_lat = 6;
    issue(32'h0040_0456, 2'd2, "R10 walk under old base");
    chk("R8 ready low during walk", {63'd0, xl_ready}, 64'd0);
    wr_base(32'h0009_0000);
    wr_base(32'h0001_0000);                                   // last write wins
    fixed_lat = 0;
    issue(32'h0040_1010, 2'd0, "R10 deferred base applied");
    issue(32'h0040_2020, 2'd1, "R10 store after switch");
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R2 R4 no outstanding reads", 64'(addr_q.size()), 64'd0);
    chk("R8 no extra done", {63'd0, xl_done}, 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule